// File: doc/BRIEF.md
# Multiplier Test Operand Sequencer

This block produces a stream of operand pairs for a multiplier under test and for a reference multiplier running beside it. A 16-bit pattern word is split into two 8-bit factors, one new word per clock. A pass begins with a start pulse. It then presents exactly 2**PASS_W words (65536 by default) and signals its last word with a done strobe. The walk through the pattern space follows a mode picked at start: increment, decrement, increment or decrement by a programmed stride, a 16-bit maximal-length LFSR, or a toggle between two factor pairs whose product is always zero.

Alongside each word the block also drives the word that preceded it. A comparison stage downstream can then record which input transition came before a wrong product, since timing faults in a multiplier often depend on the previous operands and not only the present ones.

Top module: `opnd_seq`

## Requirements
- R1: `fac_a` carries bits 7:0 of the current pattern and `fac_b` carries bits 15:8. `prev_a` and `prev_b` split the previous pattern the same way.
- R2: Mode 0 (and the unused codes 6 and 7) starts the pass at 0x0000 and adds 1 to the pattern each cycle.
- R3: Mode 1 starts the pass at 0x0000 and subtracts 1 each cycle, wrapping modulo 65536, so the second word is 0xFFFF.
- R4: Mode 2 adds the latched stride each cycle and mode 3 subtracts it, both starting at 0x0000 and wrapping modulo 65536. A stride input of zero is taken as 1.
- R5: Mode 4 starts at the seed, or at 0x0001 when the seed is zero. Each later word is {p[14:0], p[15]^p[13]^p[12]^p[10]}, so the word is never zero.
- R6: Mode 5 presents 0x00FF first and then alternates with 0x0100 every cycle.
- R7: After a start pulse is sampled while idle, `valid` is high for exactly 2**PASS_W consecutive cycles starting the next cycle. `done` is high only during the final one of them. A wrap of the pattern does not end the pass early.
- R8: While `valid` is high, the previous-pair outputs equal the pattern of the preceding cycle. They are zero for the first word of a pass.
- R9: `start`, `mode`, `step` and `seed` are ignored while a pass is running.
- R10: After reset, `valid` and `done` are low and all factor outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a pass when idle |
| mode | input | 3 | Sequencing mode code, sampled at start |
| step | input | STEP_W | Stride for the stepped modes, sampled at start |
| seed | input | 16 | LFSR seed for mode 4, sampled at start |
| valid | output | 1 | Current pattern belongs to a running pass |
| done | output | 1 | Current pattern is the last of the pass |
| fac_a | output | 8 | Current factor A (pattern low byte) |
| fac_b | output | 8 | Current factor B (pattern high byte) |
| prev_a | output | 8 | Factor A of the preceding cycle |
| prev_b | output | 8 | Factor B of the preceding cycle |

## Verification
The in-line properties assume that reset is held until the clock runs. They also assume that the mode, stride and seed in use come only from values latched at start, so the bench changes those inputs and pulses start in the middle of a pass to show that the running sequence does not change. The bench works with a shortened pass length, which keeps every mode, including a downward wrap through zero, to a full pass of checked words. Each new pass is started only after `valid` has dropped, so every start lands in the idle state the properties expect.

// File: rtl/opnd_seq.sv
module opnd_seq #(
  parameter int PASS_W = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [STEP_W-1:0] step,
  input  logic [15:0]       seed,
  output logic              valid,
  output logic              done,
  output logic [7:0]        fac_a,
  output logic [7:0]        fac_b,
  output logic [7:0]        prev_a,
  output logic [7:0]        prev_b
);
  localparam logic [2:0] M_UP   = 3'd0;
  localparam logic [2:0] M_DOWN = 3'd1;
  localparam logic [2:0] M_SUP  = 3'd2;
  localparam logic [2:0] M_SDN  = 3'd3;
  localparam logic [2:0] M_RND  = 3'd4;
  localparam logic [2:0] M_ALT  = 3'd5;
  localparam logic [15:0] ALT_X = 16'h00FF;
  localparam logic [15:0] ALT_Y = 16'h0100;

  logic              busy;
  logic [2:0]        mode_q;
  logic [STEP_W-1:0] step_q;
  logic [PASS_W-1:0] cnt;
  logic [15:0]       pat, prev, nxt, init;
  logic              last;

  assign last   = (cnt == {PASS_W{1'b1}});
  assign valid  = busy;
  assign done   = busy && last;
  assign fac_a  = pat[7:0];
  assign fac_b  = pat[15:8];
  assign prev_a = prev[7:0];
  assign prev_b = prev[15:8];

  always_comb begin
    case (mode)
      M_RND:   init = (seed == 16'd0) ? 16'd1 : seed;
      M_ALT:   init = ALT_X;
      default: init = 16'd0;
    endcase
  end

  always_comb begin
    case (mode_q)
      M_DOWN:  nxt = pat - 16'd1;
      M_SUP:   nxt = pat + 16'(step_q);
      M_SDN:   nxt = pat - 16'(step_q);
      M_RND:   nxt = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
      M_ALT:   nxt = (pat == ALT_X) ? ALT_Y : ALT_X;
      default: nxt = pat + 16'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= M_UP;
      step_q <= STEP_W'(1);
      cnt    <= '0;
      pat    <= 16'd0;
      prev   <= 16'd0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        mode_q <= mode;
        step_q <= (step == '0) ? STEP_W'(1) : step;
        cnt    <= '0;
        pat    <= init;
        prev   <= 16'd0;
      end
    end else begin
      pat  <= nxt;
      prev <= pat;
      cnt  <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && mode_q == M_UP) |=> ({fac_b, fac_a} == $past(pat) + 16'd1));

  assert_rnd_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == M_RND) |-> ({fac_b, fac_a} != 16'd0));

  assert_alt_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == M_ALT) |-> ((fac_a == 8'hFF && fac_b == 8'h00) ||
                                   (fac_a == 8'h00 && fac_b == 8'h01)));

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !valid);

  assert_start_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (valid && {prev_b, prev_a} == 16'd0));

  assert_prev_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ({prev_b, prev_a} == $past({fac_b, fac_a})));
endmodule

// File: tb/test_opnd_seq.sv
module test_opnd_seq;
  localparam int PASS_W = 10;
  localparam int STEP_W = 4;
  localparam int NPAT   = 1 << PASS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [STEP_W-1:0] step = '0;
  logic [15:0] seed = 16'd0;
  logic valid, done;
  logic [7:0] fac_a, fac_b, prev_a, prev_b;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  opnd_seq #(.PASS_W(PASS_W), .STEP_W(STEP_W)) i_opnd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .step(step), .seed(seed),
    .valid(valid), .done(done), .fac_a(fac_a), .fac_b(fac_b),
    .prev_a(prev_a), .prev_b(prev_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_next(input logic [2:0] m, input logic [STEP_W-1:0] s,
                                             input logic [15:0] p);
    logic [15:0] st;
    st = (s == '0) ? 16'd1 : 16'(s);
    case (m)
      3'd1: return p - 16'd1;
      3'd2: return p + st;
      3'd3: return p - st;
      3'd4: return {p[14:0], p[15] ^ p[13] ^ p[12] ^ p[10]};
      3'd5: return (p == 16'h00FF) ? 16'h0100 : 16'h00FF;
      default: return p + 16'd1;
    endcase
  endfunction

  // Runs one pass and compares every word; optionally disturbs the inputs mid-pass (R9).
  task automatic run_pass(input logic [2:0] m, input logic [STEP_W-1:0] s, input logic [15:0] sd,
                          input logic [15:0] first, input string req, input bit disturb);
    logic [15:0] exp, expp;
    mode = m; step = s; seed = sd; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    exp = first; expp = 16'd0;
    for (int i = 0; i < NPAT; i++) begin
      chk(valid === 1'b1, "R7 valid", {31'd0, valid}, 32'd1);
      chk({fac_b, fac_a} === exp, req, {16'd0, fac_b, fac_a}, {16'd0, exp});
      chk({prev_b, prev_a} === expp, "R8 prev", {16'd0, prev_b, prev_a}, {16'd0, expp});
      chk(done === (i == NPAT - 1), "R7 done", {31'd0, done}, {31'd0, i == NPAT - 1});
      if (disturb && i == 10) begin
        mode = 3'd5; step = 4'd7; seed = 16'h1234; start = 1'b1;
      end
      if (disturb && i == 11) start = 1'b0;
      expp = exp;
      exp = model_next(m, s, exp);
      @(negedge clk);
    end
    chk(valid === 1'b0 && done === 1'b0, "R7 end", {30'd0, valid, done}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(valid === 1'b0 && done === 1'b0, "R10 flags", {30'd0, valid, done}, 32'd0);
    chk({fac_b, fac_a, prev_b, prev_a} === 32'd0, "R10 factors",
        {fac_b, fac_a, prev_b, prev_a}, 32'd0);
  endtask

  task automatic t_up;          run_pass(3'd0, 4'd0, 16'd0, 16'h0000, "R2 up", 1'b0); endtask
  task automatic t_up_alias;    run_pass(3'd7, 4'd0, 16'd0, 16'h0000, "R2 code7", 1'b0); endtask
  task automatic t_down;        run_pass(3'd1, 4'd0, 16'd0, 16'h0000, "R3 down", 1'b0); endtask
  task automatic t_step_up;     run_pass(3'd2, 4'd3, 16'd0, 16'h0000, "R4 step+3", 1'b0); endtask
  task automatic t_step_down;   run_pass(3'd3, 4'd3, 16'd0, 16'h0000, "R4 step-3", 1'b0); endtask
  task automatic t_step_zero;   run_pass(3'd2, 4'd0, 16'd0, 16'h0000, "R4 step0", 1'b0); endtask
  task automatic t_rnd;         run_pass(3'd4, 4'd0, 16'hACE1, 16'hACE1, "R5 lfsr", 1'b0); endtask
  task automatic t_rnd_zero;    run_pass(3'd4, 4'd0, 16'h0000, 16'h0001, "R5 seed0", 1'b0); endtask
  task automatic t_alt;         run_pass(3'd5, 4'd0, 16'd0, 16'h00FF, "R6 alt", 1'b0); endtask
  task automatic t_ignore;      run_pass(3'd0, 4'd0, 16'd0, 16'h0000, "R9 ignore", 1'b1); endtask

  task automatic t_split;
    mode = 3'd4; seed = 16'hA55A; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(fac_a === 8'h5A, "R1 fac_a", {24'd0, fac_a}, 32'h5A);
    chk(fac_b === 8'hA5, "R1 fac_b", {24'd0, fac_b}, 32'hA5);
    @(negedge clk);
    chk(prev_a === 8'h5A && prev_b === 8'hA5, "R1 prev split", {16'd0, prev_b, prev_a}, 32'hA55A);
    while (valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_split;
    t_up;
    t_up_alias;
    t_down;
    t_step_up;
    t_step_down;
    t_step_zero;
    t_rnd;
    t_rnd_zero;
    t_alt;
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule